// File: doc/BRIEF.md
# Two-Wire Register Slave for a Power-Management Controller

This block is the serial control port of a power-management controller. It watches the two-wire bus lines, which are oversampled by a much faster system clock, and answers a 7-bit slave address. That address is chosen by a strap input that has three levels. Through this port a host can reach a bank of thirteen 8-bit registers.

A register pointer is loaded by the first byte after the address. Every byte that follows moves the pointer forward by one, for writes and for reads alike. Two registers cannot be written. One of them shows a live status word. The other holds sticky event flags, and reading it clears them. The block sends out a one-cycle strobe whenever that flag register is read. It also drives an active-low interrupt line that stays low while any flag is set.

The data line is open-drain. The block only asserts a pull-low enable and never drives the line high. Every writable register appears on a flat configuration output, so the rest of the controller can use it directly.

Top module: `pmic_i2c_regfile`

## Requirements
- R1: The slave address is latched from `strap_i` while reset is held. The encoding is 2'b01 for 0x7F, 2'b00 for 0x7D, and 2'b10 or 2'b11 for 0x7C. A change of the strap after reset has no effect.
- R2: A write transaction is START, then the address with bit 0 at 0, then a pointer byte, then data bytes, then STOP. The slave acknowledges the address, the pointer and every data byte, and each data byte is stored at the pointer.
- R3: The pointer increments after each data byte that is written. Consecutive bytes of one transaction therefore land at consecutive registers.
- R4: A read transaction sets the pointer with a write phase, followed by a repeated START and the address with bit 0 at 1. The slave returns register contents MSB first. The pointer advances after every byte that the master acknowledges.
- R5: When the master does not acknowledge a read byte, the slave releases the data line and drives nothing until the next START.
- R6: Bytes are shifted MSB first. The slave acknowledges by pulling the data line low during the ninth clock. It changes its drive only while the clock is low.
- R7: A START or STOP condition in the middle of a byte aborts the transaction, and the partial byte is not written. After a mid-byte START, a new address phase follows.
- R8: Register 0x0A returns `status_i` and register 0x0B returns the flag register. Writes to either of them are acknowledged but have no effect.
- R9: A read of 0x0B returns the flags, clears them, releases `irq_n_o` and pulses `flag_rd_o` high for one cycle.
- R10: Each bit set in `flag_set_i` sets the matching flag bit, and it stays set until the flags are read. `irq_n_o` is low while any flag is set.
- R11: The slave does not acknowledge an address that does not match. It then ignores the bus until the next START or STOP.
- R12: A read of any pointer value above 0x0C returns 0x00. A write to such a pointer is acknowledged and discarded.
- R13: After reset the data line is released and `irq_n_o` is high. The writable registers hold the values of `RST_VAL`, and the flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low reset; the strap is latched while it is low |
| strap_i | input | 2 | Address strap level: 01 high, 00 low, 1x floating |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_pull_o | output | 1 | Pull-low enable for the open-drain data line |
| status_i | input | 8 | Live status word read at pointer 0x0A |
| flag_set_i | input | 8 | Per-bit set requests for the flag register |
| flag_rd_o | output | 1 | One-cycle strobe when the flag register is read |
| irq_n_o | output | 1 | Active-low interrupt, low while any flag is set |
| cfg_o | output | 104 | Register bank, byte i at bits 8i+7..8i |

## Verification
On every cycle, the assertions check three things. The data-line drive stays still while the clock has been high for several samples. The flags stick once they are set. A flag read leaves the interrupt released and gives a single-cycle strobe. Anything tied to bus framing can only be shown by the bench's scenarios, which are the only place it is observable. That covers address matching for each strap level, pointer increment across the read-only slots, the release after a NACK, and aborts by START or STOP in the middle of a byte.

// File: rtl/pmic_i2c_regfile.sv
module pmic_i2c_regfile #(
  parameter int NREG = 13,
  parameter int STATUS_IDX = 10,
  parameter int FLAG_IDX = 11,
  parameter logic [6:0] ADDR_HIGH = 7'h7F,
  parameter logic [6:0] ADDR_FLOAT = 7'h7C,
  parameter logic [6:0] ADDR_LOW = 7'h7D,
  parameter logic [NREG*8-1:0] RST_VAL = 104'h03_00_00_3F_E5_FF_63_75_75_7D_7D_7D_01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        strap_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic [7:0]        status_i,
  input  logic [7:0]        flag_set_i,
  output logic              flag_rd_o,
  output logic              irq_n_o,
  output logic [NREG*8-1:0] cfg_o
);
  localparam int IW = $clog2(NREG);
  localparam logic [7:0] NREG_B = 8'(NREG);
  localparam logic [7:0] STAT_B = 8'(STATUS_IDX);
  localparam logic [7:0] FLAG_B = 8'(FLAG_IDX);

  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_PTR, ST_WR, ST_RD, ST_SKIP} st_t;

  logic [1:0] scl_m, sda_m;
  logic       scl_q, sda_q;
  logic [6:0] my_addr;
  st_t        st;
  logic [3:0] cnt;
  logic [7:0] shreg, ptr, tx, flags, rd_val;
  logic       rw;
  logic [7:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 2'b11;
      sda_m <= 2'b11;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_m <= {scl_m[0], scl_i};
      sda_m <= {sda_m[0], sda_i};
      scl_q <= scl_m[1];
      sda_q <= sda_m[1];
    end
  end

  wire scl_s     = scl_m[1];
  wire sda_s     = sda_m[1];
  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire bus_start = scl_s & scl_q & sda_q & ~sda_s;
  wire bus_stop  = scl_s & scl_q & ~sda_q & sda_s;

  always_ff @(posedge clk)
    if (!rst_n)
      my_addr <= (strap_i == 2'b01) ? ADDR_HIGH :
                 (strap_i == 2'b00) ? ADDR_LOW  : ADDR_FLOAT;

  wire [7:0] byte_now = {shreg[6:0], sda_s};
  wire active   = (st != ST_IDLE) && (st != ST_SKIP);
  wire wr_ok    = (ptr < NREG_B) && (ptr != STAT_B) && (ptr != FLAG_B);
  wire wr_en    = active && !bus_start && !bus_stop && scl_rise &&
                  cnt == 4'd7 && st == ST_WR && wr_ok;
  wire load     = active && !bus_start && !bus_stop && scl_fall &&
                  st == ST_RD && cnt == 4'd0;
  wire flag_clr = load && ptr == FLAG_B;

  always_comb begin
    if (ptr == STAT_B)      rd_val = status_i;
    else if (ptr == FLAG_B) rd_val = flags;
    else if (ptr < NREG_B)  rd_val = regs[ptr[IW-1:0]];
    else                    rd_val = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      cnt <= '0;
      shreg <= '0;
      ptr <= '0;
      tx <= '0;
      rw <= 1'b0;
      sda_pull_o <= 1'b0;
      flag_rd_o <= 1'b0;
    end else begin
      flag_rd_o <= flag_clr;
      if (bus_start) begin
        st <= ST_ADDR;
        cnt <= '0;
        sda_pull_o <= 1'b0;
      end else if (bus_stop) begin
        st <= ST_IDLE;
        cnt <= '0;
        sda_pull_o <= 1'b0;
      end else if (active) begin
        if (scl_rise) begin
          if (cnt == 4'd8) begin
            cnt <= '0;
            case (st)
              ST_ADDR: st <= rw ? ST_RD : ST_PTR;
              ST_PTR:  st <= ST_WR;
              ST_RD:   if (sda_s) st <= ST_SKIP; else ptr <= ptr + 8'd1;
              default: ;
            endcase
          end else begin
            cnt <= cnt + 4'd1;
            shreg <= byte_now;
            if (cnt == 4'd7) begin
              case (st)
                ST_ADDR: if (byte_now[7:1] == my_addr) rw <= byte_now[0];
                         else st <= ST_SKIP;
                ST_PTR:  ptr <= byte_now;
                ST_WR:   ptr <= ptr + 8'd1;
                default: ;
              endcase
            end
          end
        end else if (scl_fall) begin
          if (st == ST_RD) begin
            if (cnt == 4'd0) begin
              tx <= rd_val;
              sda_pull_o <= ~rd_val[7];
            end else if (cnt < 4'd8) begin
              sda_pull_o <= ~tx[3'd7 - cnt[2:0]];
            end else begin
              sda_pull_o <= 1'b0;
            end
          end else begin
            sda_pull_o <= (cnt == 4'd8);
          end
        end
      end else if (scl_fall) begin
        sda_pull_o <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= RST_VAL[i*8 +: 8];
    end else if (wr_en) begin
      regs[ptr[IW-1:0]] <= byte_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flag_clr ? 8'h00 : flags) | flag_set_i;
  end

  assign irq_n_o = ~|flags;

  for (genvar g = 0; g < NREG; g++) begin : g_cfg
    if (g == STATUS_IDX) begin : g_stat
      assign cfg_o[g*8 +: 8] = status_i;
    end else if (g == FLAG_IDX) begin : g_flag
      assign cfg_o[g*8 +: 8] = flags;
    end else begin : g_reg
      assign cfg_o[g*8 +: 8] = regs[g];
    end
  end
endmodule

// File: rtl/pmic_i2c_regfile_chk.sv
module pmic_i2c_regfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_pull_o,
  input logic [7:0] flag_set_i,
  input logic       flag_rd_o,
  input logic       irq_n_o
);
  AST_SDA_HOLD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && $past(scl_i, 2) && $past(scl_i, 3)) |-> $stable(sda_pull_o)); // R6

  AST_FLAG_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flag_rd_o |-> (irq_n_o || $past(flag_set_i) != 8'h00)); // R9

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    flag_rd_o |=> !flag_rd_o); // R9

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_set_i != 8'h00) |=> !irq_n_o); // R10
endmodule

bind pmic_i2c_regfile pmic_i2c_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_pull_o(sda_pull_o),
  .flag_set_i(flag_set_i), .flag_rd_o(flag_rd_o), .irq_n_o(irq_n_o)
);

// File: tb/test_pmic_i2c_regfile.sv
module test_pmic_i2c_regfile;
  localparam int Q = 8;
  localparam logic [103:0] RST_EXP = 104'h03_00_00_3F_E5_FF_63_75_75_7D_7D_7D_01;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst_n, scl, m_low;
  logic [1:0]   strap;
  logic [7:0]   status, fset;
  wire          pull, flag_rd, irq_n;
  wire  [103:0] cfg;
  wire          sda = ~(m_low | pull);

  pmic_i2c_regfile i_pmic_i2c_regfile (
    .clk(clk), .rst_n(rst_n), .strap_i(strap), .scl_i(scl), .sda_i(sda),
    .sda_pull_o(pull), .status_i(status), .flag_set_i(fset),
    .flag_rd_o(flag_rd), .irq_n_o(irq_n), .cfg_o(cfg)
  );

  int checks = 0, fails = 0, rd_pulses = 0;
  logic [6:0] dev;
  logic [7:0] exp_q[$];
  logic [7:0] got_b;
  string      cur_req;
  event       got_ev;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) if (rst_n && flag_rd) rd_pulses++;

  initial begin
    forever begin
      @(got_ev);
      if (exp_q.size() == 0) chk({cur_req, " unexpected byte"}, 32'(got_b), 32'hFFFF);
      else chk(cur_req, 32'(got_b), 32'(exp_q.pop_front()));
    end
  end

  task automatic qw(int n = 1);
    repeat (n * Q) @(posedge clk);
    #1;
  endtask

  task automatic bstart();   m_low = 1; qw(); scl = 0; qw(); endtask
  task automatic brestart(); m_low = 0; qw(); scl = 1; qw(); m_low = 1; qw(); scl = 0; qw(); endtask
  task automatic bstop();    m_low = 1; qw(); scl = 1; qw(); m_low = 0; qw(2); endtask
  task automatic sbit(logic b); m_low = ~b; qw(); scl = 1; qw(2); scl = 0; qw(); endtask

  task automatic wbyte(logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) sbit(b[i]);
    m_low = 0; qw(); scl = 1; qw(); ack = ~sda; qw(); scl = 0; qw();
  endtask

  task automatic rbyte(logic nack, output logic [7:0] b);
    m_low = 0;
    for (int i = 0; i < 8; i++) begin
      qw(); scl = 1; qw(); b = {b[6:0], sda}; qw(); scl = 0; qw();
    end
    m_low = ~nack; qw(); scl = 1; qw(2); scl = 0; qw(); m_low = 0;
  endtask

  task automatic write_regs(logic [7:0] ptr, logic [7:0] data[$], string req);
    logic a;
    bstart();
    wbyte({dev, 1'b0}, a); chk({req, " R6 address ACK"}, 32'(a), 1);
    wbyte(ptr, a);         chk({req, " pointer ACK"}, 32'(a), 1);
    foreach (data[i]) begin
      wbyte(data[i], a);   chk({req, " data ACK"}, 32'(a), 1);
    end
    bstop();
  endtask

  task automatic read_expect(logic [7:0] ptr, logic [7:0] exp[$], string req);
    logic a;
    logic [7:0] b;
    cur_req = req;
    foreach (exp[i]) exp_q.push_back(exp[i]);
    bstart();
    wbyte({dev, 1'b0}, a); chk({req, " write-phase ACK"}, 32'(a), 1);
    wbyte(ptr, a);         chk({req, " pointer ACK"}, 32'(a), 1);
    brestart();
    wbyte({dev, 1'b1}, a); chk({req, " read address ACK"}, 32'(a), 1);
    for (int i = 0; i < exp.size(); i++) begin
      rbyte(i == exp.size() - 1, b);
      got_b = b;
      ->got_ev;
    end
    chk("R5 released after NACK", 32'(pull), 0);
    qw(2);
    chk("R5 still released", 32'(pull), 0);
    bstop();
  endtask

  task automatic do_reset(logic [1:0] s);
    rst_n = 0; strap = s; scl = 1; m_low = 0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    qw();
  endtask

  task automatic pulse_flags(logic [7:0] v);
    @(posedge clk); #1 fset = v;
    @(posedge clk); #1 fset = 8'h00;
  endtask

  task automatic finish_run();
    chk("R4 scoreboard drained", 32'(exp_q.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic a;
    int p0;
    status = 8'h00; fset = 8'h00;
    do_reset(2'b10);
    dev = 7'h7C;
    @(negedge clk);
    chk("R13 data line released", 32'(pull), 0);
    chk("R13 irq high", 32'(irq_n), 1);
    chk("R13 cfg reset low", cfg[31:0], RST_EXP[31:0]);
    chk("R13 cfg reset high", {8'h0, cfg[103:80]}, {8'h0, RST_EXP[103:80]});

    // R1 floating strap, R2 single write
    write_regs(8'h01, '{8'hA5}, "R2");
    @(negedge clk) chk("R2 cfg byte 1", 32'(cfg[15:8]), 32'hA5);
    read_expect(8'h01, '{8'hA5}, "R1 float address read");

    // R3 burst write, R4 burst read
    write_regs(8'h02, '{8'h11, 8'h22, 8'h33}, "R3");
    @(negedge clk) chk("R3 cfg bytes 2..4", 32'(cfg[39:16]), 32'h332211);
    read_expect(8'h02, '{8'h11, 8'h22, 8'h33}, "R4 burst read");

    // R8 read-only slots skipped by writes
    status = 8'h5A;
    write_regs(8'h09, '{8'h66, 8'h77, 8'h88, 8'h99}, "R8");
    read_expect(8'h09, '{8'h66, 8'h5A, 8'h00, 8'h99}, "R8 read-only slots");

    // R10 sticky flags, R9 clear on read
    pulse_flags(8'h03);
    @(negedge clk) chk("R10 irq low after set", 32'(irq_n), 0);
    qw(4);
    pulse_flags(8'h04);
    @(negedge clk) chk("R10 irq still low", 32'(irq_n), 0);
    p0 = rd_pulses;
    read_expect(8'h0B, '{8'h07}, "R9 flag read");
    @(negedge clk);
    chk("R9 irq released", 32'(irq_n), 1);
    chk("R9 one strobe", 32'(rd_pulses - p0), 1);
    read_expect(8'h0B, '{8'h00}, "R9 flags cleared");

    // R12 unimplemented pointer
    write_regs(8'h20, '{8'h3C}, "R12");
    read_expect(8'h20, '{8'h00}, "R12 empty read");
    read_expect(8'h0C, '{8'h99}, "R12 neighbour untouched");

    // R11 foreign address
    bstart();
    wbyte({7'h50, 1'b0}, a); chk("R11 foreign address NACK", 32'(a), 0);
    wbyte(8'h01, a);         chk("R11 ignored pointer", 32'(a), 0);
    wbyte({dev, 1'b0}, a);   chk("R11 ignored own address", 32'(a), 0);
    wbyte(8'hEE, a);
    bstop();
    bstart();
    wbyte({7'h7F, 1'b1}, a); chk("R11 foreign read NACK", 32'(a), 0);
    bstop();
    read_expect(8'h01, '{8'hA5}, "R11 register kept");

    // R7 mid-byte STOP
    bstart();
    wbyte({dev, 1'b0}, a);
    wbyte(8'h01, a);
    sbit(1); sbit(1); sbit(1); sbit(1);
    m_low = 1; qw(); scl = 1; qw(); m_low = 0; qw(2);
    read_expect(8'h01, '{8'hA5}, "R7 stop abort");

    // R7 mid-byte START then new transaction
    bstart();
    wbyte({dev, 1'b0}, a);
    wbyte(8'h01, a);
    sbit(0); sbit(0); sbit(0);
    m_low = 0; qw(); scl = 1; qw(); m_low = 1; qw(); scl = 0; qw();
    wbyte({dev, 1'b0}, a); chk("R7 address after restart", 32'(a), 1);
    wbyte(8'h05, a);
    wbyte(8'h42, a);
    bstop();
    read_expect(8'h05, '{8'h42}, "R7 new transaction");
    read_expect(8'h01, '{8'hA5}, "R7 partial byte dropped");

    // R1 other strap levels
    do_reset(2'b01);
    bstart();
    wbyte({7'h7C, 1'b0}, a); chk("R1 old address rejected", 32'(a), 0);
    bstop();
    dev = 7'h7F;
    read_expect(8'h01, '{8'h7D}, "R1 high strap and R13 reset value");
    strap = 2'b00;
    read_expect(8'h00, '{8'h01}, "R1 strap change ignored");
    do_reset(2'b00);
    dev = 7'h7D;
    write_regs(8'h07, '{8'hC3}, "R1 low strap");
    read_expect(8'h07, '{8'hC3}, "R1 low strap read");

    qw(4);
    finish_run();
  end
endmodule